// File: doc/BRIEF.md
# Reloadable Expiry Down Timer

This block is an interval timer that counts down from a value supplied at the moment it is started. A one-cycle load strobe captures a parallel start value into the internal count. The machine then passes through a short setup state, lowers the count by one on every following clock and, when the count arrives at zero, enters a terminal state in which a registered expiry flag is raised.

The expiry condition is sticky. The flag and the zero count hold for as long as no new load arrives. A load is accepted in every state: it recaptures the start value, clears the flag and sends the machine back to its setup state. A countdown in progress can therefore be restarted, and an expired timer can be rearmed, with the same strobe. The current count is brought out so that a user can watch the countdown. The machine has three states: setup, counting and expired. After reset it waits idle in setup until the first load arrives.

Top module: `exp_timer`

## Requirements
- R1: After reset, `expired` is 0 and `count` is 0, and with no load the timer stays idle with `expired` held at 0.
- R2: On the clock edge where `load` is 1, `count` takes the value of `start_val` and `expired` becomes 0.
- R3: After a nonzero load, `count` holds the loaded value for one more clock (the setup state) and then falls by exactly one on each later clock.
- R4: For a start value N, `expired` first reads 1 exactly N+1 clock edges after the load edge, with `count` equal to 0. One edge earlier, `expired` is 0.
- R5: Once raised, `expired` stays 1 and `count` stays 0 on every clock where `load` is 0.
- R6: A load during a countdown discards the old count and restarts the countdown from the new start value, with the timing of R3 and R4.
- R7: A start value of 0 raises `expired` on the first clock edge after the load edge.
- R8: A load while expired clears `expired` on that edge, and the new countdown expires by the timing of R4.
- R9: `load` takes priority over counting and expiry. A load on the edge where the count would reach zero reloads the count and does not raise `expired`.
- R10: The largest start value, 2^CNT_W-1, counts down to 0 with no wraparound and expires by the timing of R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Start or restart strobe, sampled on each rising edge |
| start_val | input | CNT_W | Start value captured when `load` is 1 |
| expired | output | 1 | Registered flag, held at 1 from the moment the count reaches zero until the next load |
| count | output | CNT_W | Current value of the countdown |

## Verification
The bench builds the timer with CNT_W set to 8. At that width the largest start value, 255, runs all the way to expiry in a few hundred cycles, so the no-wraparound boundary of R10 is exercised directly and not inferred. The same count logic and state machine are used at the 32-bit default, so the small width still covers every state transition: zero start, reload during counting, a load on the edge of reaching zero, and rearming from the expired state.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_DEC  = 2'd1,
    ST_EXP  = 2'd2
  } tmr_state_e;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_DEC  = 2'd2
  } cnt_op_e;

endpackage

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  tmr_pkg::cnt_op_e     op,
  input  logic [CNT_W-1:0]     start_val,
  output logic [CNT_W-1:0]     cnt_q,
  output logic                 is_zero,
  output logic                 is_one,
  output logic                 start_zero
);
  import tmr_pkg::*;

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return v - ONE;
  endfunction

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    unique case (op)
      OP_LOAD: cnt_d = start_val;
      OP_DEC:  cnt_d = step_down(cnt_q);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign is_zero    = (cnt_q == '0);
  assign is_one     = (cnt_q == ONE);
  assign start_zero = (start_val == '0);

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic                 is_zero,
  input  logic                 is_one,
  output tmr_pkg::tmr_state_e  st_q,
  output logic                 armed_q,
  output logic                 exp_q,
  output tmr_pkg::cnt_op_e     op
);
  import tmr_pkg::*;

  tmr_state_e st_d;
  logic       armed_d;
  logic       exp_d;

  always_comb begin
    st_d    = st_q;
    armed_d = armed_q;
    exp_d   = exp_q;
    op      = OP_HOLD;
    if (load) begin
      op      = OP_LOAD;
      st_d    = ST_INIT;
      armed_d = 1'b1;
      exp_d   = 1'b0;
    end else begin
      unique case (st_q)
        ST_INIT: begin
          if (armed_q) begin
            if (is_zero) begin
              st_d  = ST_EXP;
              exp_d = 1'b1;
            end else begin
              st_d = ST_DEC;
            end
          end
        end
        ST_DEC: begin
          op = OP_DEC;
          if (is_one) begin
            st_d  = ST_EXP;
            exp_d = 1'b1;
          end
        end
        ST_EXP: begin
          exp_d = 1'b1;
        end
        default: begin
          st_d  = ST_INIT;
          exp_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_INIT;
      armed_q <= 1'b0;
      exp_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      armed_q <= armed_d;
      exp_q   <= exp_d;
    end
  end

endmodule

// File: rtl/exp_timer.sv
module exp_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] start_val,
  output logic             expired,
  output logic [CNT_W-1:0] count
);
  import tmr_pkg::*;

  cnt_op_e          op;
  tmr_state_e       st_q;
  logic             armed_q;
  logic             exp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             is_zero;
  logic             is_one;
  logic             start_zero;

  // named events for the checker
  logic ld_evt;
  logic dec_evt;
  logic hit_zero;

  tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .start_val (start_val),
    .cnt_q     (cnt_q),
    .is_zero   (is_zero),
    .is_one    (is_one),
    .start_zero(start_zero)
  );

  tmr_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .is_zero (is_zero),
    .is_one  (is_one),
    .st_q    (st_q),
    .armed_q (armed_q),
    .exp_q   (exp_q),
    .op      (op)
  );

  assign ld_evt   = (op == OP_LOAD);
  assign dec_evt  = (op == OP_DEC);
  assign hit_zero = is_zero;

  assign expired = exp_q;
  assign count   = cnt_q;

endmodule

// File: rtl/exp_timer_chk.sv
module exp_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             load,
  input logic [CNT_W-1:0] start_val,
  input logic             expired,
  input logic [CNT_W-1:0] count,
  input logic [1:0]       st_q,
  input logic             ld_evt,
  input logic             dec_evt,
  input logic             hit_zero
);

  // R2: a load captures the start value and clears the flag
  p_load_capture_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> (!expired && count == $past(start_val)));

  // R3: counting lowers the count by one
  p_step_down_r3: assert property (@(posedge clk) disable iff (rst)
    dec_evt |=> (count == $past(count) - CNT_W'(1)));

  // R4: the flag is raised only with a zero count
  p_flag_zero_r4: assert property (@(posedge clk) disable iff (rst)
    expired |-> hit_zero);

  // R5: the flag is sticky while no load arrives
  p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (expired && !load) |=> (expired && $stable(count)));

  // R9: load wins over counting
  p_load_priority_r9: assert property (@(posedge clk) disable iff (rst)
    load |-> (ld_evt && !dec_evt));

  // R1: state encoding stays legal
  p_legal_state_r1: assert property (@(posedge clk) disable iff (rst)
    st_q != 2'd3);

endmodule

bind exp_timer exp_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .load     (load),
  .start_val(start_val),
  .expired  (expired),
  .count    (count),
  .st_q     (st_q),
  .ld_evt   (ld_evt),
  .dec_evt  (dec_evt),
  .hit_zero (hit_zero)
);

// File: tb/exp_timer_bench.sv
module exp_timer_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load = 1'b0;
  logic [W-1:0] start_val = '0;
  logic         expired;
  logic [W-1:0] count;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  exp_timer #(.CNT_W(W)) u_exp_timer (
    .clk(clk), .rst(rst), .load(load), .start_val(start_val),
    .expired(expired), .count(count)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // drive a one-cycle load; returns sampled just after the load edge
  task automatic do_load(input int v);
    start_val = W'(v);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic t_reset_idle();
    check(expired == 1'b0, "R1", int'(expired), 0);
    check(count == '0, "R1", int'(count), 0);
    tick(20);
    check(expired == 1'b0, "R1", int'(expired), 0);
  endtask

  // full countdown of value n with timing checks
  task automatic run_count(input int n, input string req);
    do_load(n);
    check(count == W'(n), "R2", int'(count), n);
    check(expired == 1'b0, "R2", int'(expired), 0);
    if (n > 0) begin
      tick(1);
      check(count == W'(n), "R3", int'(count), n);
      if (n > 1) begin
        tick(1);
        check(count == W'(n-1), "R3", int'(count), n-1);
        tick(n-2);
      end
      check(expired == 1'b0 && count == W'(1), req, int'(count), 1);
      tick(1);
    end else begin
      tick(1);
    end
    check(expired == 1'b1, req, int'(expired), 1);
    check(count == '0, req, int'(count), 0);
  endtask

  task automatic t_sticky();
    tick(15);
    check(expired == 1'b1, "R5", int'(expired), 1);
    check(count == '0, "R5", int'(count), 0);
  endtask

  task automatic t_restart();
    do_load(40);
    tick(10);
    check(count == W'(31), "R6", int'(count), 31);
    run_count(6, "R6");
  endtask

  task automatic t_rearm();
    check(expired == 1'b1, "R8", int'(expired), 1);
    do_load(3);
    check(expired == 1'b0, "R8", int'(expired), 0);
    tick(4);
    check(expired == 1'b1, "R8", int'(expired), 1);
  endtask

  task automatic t_priority();
    do_load(5);
    tick(5);
    check(count == W'(1) && !expired, "R9", int'(count), 1);
    do_load(9);
    check(expired == 1'b0, "R9", int'(expired), 0);
    check(count == W'(9), "R9", int'(count), 9);
    tick(9);
    check(expired == 1'b0, "R9", int'(expired), 0);
    tick(1);
    check(expired == 1'b1, "R9", int'(expired), 1);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    t_reset_idle();
    run_count(7, "R4");
    t_sticky();
    run_count(0, "R7");
    t_restart();
    t_rearm();
    t_priority();
    run_count(1, "R4");
    run_count(255, "R10");
    t_sticky();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule